// File: doc/BRIEF.md
# Burst Read Prefetch Keeper

This block sits between the engine that streams burst read data onto a bus and a backend memory or FIFO read port. While a burst is open it reads the backend ahead of the bus. Words are held in a four-entry circular store, so the bus side can take a word on every cycle without waiting for the backend.

A burst can end while fetched words are still waiting. If the address window of that burst is set to recovery mode, those words are kept and tagged with the window number. When the next burst to the same window opens, the kept words go to the bus first, in the order they were fetched. Fetching then continues from the address after the last word that was fetched. If the window is set to any other mode, the leftovers are discarded when the burst ends. A burst to a different window also discards them and starts reading from that burst's own address. The backend can return data in the strobe cycle (unregistered mode) or on a valid pulse one cycle later (registered mode).

Top module: `burst_prefetch_keeper`

## Requirements
- R1: After reset, `fill`, `bus_valid`, `be_rd` and `burst_done` are all 0.
- R2: A burst that does not resume held words issues its first backend strobe at `burst_addr`. Each later strobe in the same run raises `be_addr` by 4 over the previous one.
- R3: `fill` never exceeds 4. No backend strobe is issued while the store, counting any word still in flight, is full.
- R4: Within a burst, `bus_data` returns backend words in fetch order. No word is skipped and no word is repeated. Each word counts as delivered on a clock edge where `bus_valid` and `bus_take` are both 1.
- R5: The mode code of window w is `win_mode[2w+1:2w]`, and code 2 selects recovery. When a recovery-window burst ends, `fill` equals the number of words fetched minus the number delivered. The next burst to that window delivers those words first and then continues the fetch addresses without a gap, ignoring its `burst_addr`.
- R6: For any mode code other than 2, `fill` is 0 one cycle after `burst_stop`. The next burst to that window starts fetching at its own `burst_addr`.
- R7: A burst that opens on a window other than the tagged one discards the held words. Its first delivered word is the backend word at its own `burst_addr`.
- R8: With `rd_sync` = 0, `be_data` is stored in the same cycle as `be_rd`. With `rd_sync` = 1, it is stored in the following cycle, when `be_valid` is high.
- R9: `burst_done` is 1 for exactly the cycle after the edge that registers `burst_stop` on an open burst.
- R10: While no burst is open, and in the `burst_stop` cycle, `be_rd` is 0. While no burst is open, `bus_valid` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_mode | input | 2*NWIN | Per-window mode code; 2 = keep leftovers |
| rd_sync | input | 1 | 0: data with strobe, 1: data one cycle later |
| burst_start | input | 1 | Opens a burst (ignored while one is open) |
| burst_win | input | WW | Window of the burst being opened |
| burst_addr | input | AW | Byte start address of the burst |
| burst_stop | input | 1 | Terminates the open burst |
| bus_take | input | 1 | Bus side accepts the presented word |
| bus_valid | output | 1 | A word is presented to the bus side |
| bus_data | output | DW | Presented word |
| burst_done | output | 1 | One-cycle pulse after termination |
| be_rd | output | 1 | Backend read strobe |
| be_addr | output | AW | Backend byte address |
| be_win | output | WW | Window of the current fetch |
| be_valid | input | 1 | Registered-mode data valid |
| be_data | input | DW | Backend read data |
| fill | output | CW | Words currently held in the store |

## Verification
Each result has a due cycle, counted from the negative edge at which the bench drives the stimulus. The `burst_done` pulse and an emptied `fill` are due one clock edge after `burst_stop`, so the bench samples them at the next negative edge. A word that is taken leaves the head of the store at the edge that follows, so `bus_data` is compared at the negative edge where `bus_take` is raised. Backend strobes and addresses are sampled at every negative edge, before the edge that acts on them. Registered-mode data is driven by a bench register one edge after the strobe, which means the written word is visible in `fill` by the next check point.

// File: rtl/burst_prefetch_keeper.sv
module burst_prefetch_keeper #(
  parameter int NWIN  = 4,
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NWIN-1:0] win_mode,
  input  logic            rd_sync,
  input  logic            burst_start,
  input  logic [WW-1:0]   burst_win,
  input  logic [AW-1:0]   burst_addr,
  input  logic            burst_stop,
  input  logic            bus_take,
  output logic            bus_valid,
  output logic [DW-1:0]   bus_data,
  output logic            burst_done,
  output logic            be_rd,
  output logic [AW-1:0]   be_addr,
  output logic [WW-1:0]   be_win,
  input  logic            be_valid,
  input  logic [DW-1:0]   be_data,
  output logic [CW-1:0]   fill
);

  localparam logic [1:0] KEEP_CODE = 2'd2;

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          active, infl, held_ok, done_q;
  logic [WW-1:0] cur_win, held_win;
  logic [AW-1:0] next_addr;

  logic open_ev, stop_ev, resume, cur_keep, flush, push, pop, room;

  assign open_ev  = burst_start && !active;
  assign stop_ev  = burst_stop && active;
  assign resume   = held_ok && (held_win == burst_win) &&
                    (win_mode[{burst_win, 1'b0} +: 2] == KEEP_CODE);
  assign cur_keep = win_mode[{cur_win, 1'b0} +: 2] == KEEP_CODE;
  assign flush    = (open_ev && !resume) || (stop_ev && !cur_keep);

  assign room  = (int'(cnt) + int'(infl)) < DEPTH;
  assign be_rd = active && !burst_stop && room;
  assign push  = rd_sync ? (be_valid && infl) : be_rd;
  assign pop   = bus_valid && bus_take;

  assign bus_valid  = active && (cnt != '0);
  assign bus_data   = store[rp];
  assign be_addr    = next_addr;
  assign be_win     = cur_win;
  assign burst_done = done_q;
  assign fill       = cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= be_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop) rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      infl      <= 1'b0;
      held_ok   <= 1'b0;
      held_win  <= '0;
      cur_win   <= '0;
      next_addr <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= stop_ev;
      infl   <= be_rd && rd_sync;
      if (open_ev) begin
        active  <= 1'b1;
        cur_win <= burst_win;
        held_ok <= 1'b0;
        if (!resume) next_addr <= burst_addr;
      end else if (stop_ev) begin
        active   <= 1'b0;
        held_ok  <= cur_keep;
        held_win <= cur_win;
      end
      if (be_rd) next_addr <= next_addr + AW'(4);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);  // R3
  AST_FULL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) == DEPTH) |-> !be_rd);  // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    be_rd |=> be_addr == $past(be_addr) + AW'(4));  // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && active) |=> burst_done);  // R9
  AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && active && !cur_keep) |=> (cnt == '0));  // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!be_rd && !bus_valid));  // R10
  AST_STOP_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop |-> !be_rd);  // R10

endmodule

// File: tb/test_burst_prefetch_keeper.sv
`timescale 1ns/1ps
module test_burst_prefetch_keeper;
  localparam int NWIN = 4, AW = 12, DW = 32, DEPTH = 4;
  localparam int WW = 2, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2*NWIN-1:0] win_mode;
  logic rd_sync = 1'b0, burst_start = 1'b0, burst_stop = 1'b0, bus_take = 1'b0;
  logic [WW-1:0] burst_win = '0;
  logic [AW-1:0] burst_addr = '0;
  logic bus_valid, burst_done, be_rd, be_valid;
  logic [DW-1:0] bus_data, be_data, d_q;
  logic [AW-1:0] be_addr;
  logic [WW-1:0] be_win;
  logic [CW-1:0] fill;

  int checks = 0, errors = 0, cycles = 0;
  int exp_fetch = 0, exp_idx = 0, fetched = 0, delivered = 0;
  int tag = -1;

  always #2.5 clk = ~clk;

  // modes: w0=2 (keep), w1=1, w2=2 (keep), w3=3
  assign win_mode = {2'd3, 2'd2, 2'd1, 2'd2};

  function automatic logic [DW-1:0] word_of(input int w, input int a);
    return DW'((w << 16) | ((a % (1 << AW)) >> 2));
  endfunction

  always_ff @(posedge clk) begin
    be_valid <= be_rd;
    d_q <= word_of(int'(be_win), int'(be_addr));
  end
  assign be_data = rd_sync ? d_q : word_of(int'(be_win), int'(be_addr));

  burst_prefetch_keeper #(.NWIN(NWIN), .AW(AW), .DW(DW), .DEPTH(DEPTH))
    i_burst_prefetch_keeper (
      .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .rd_sync(rd_sync),
      .burst_start(burst_start), .burst_win(burst_win), .burst_addr(burst_addr),
      .burst_stop(burst_stop), .bus_take(bus_take), .bus_valid(bus_valid),
      .bus_data(bus_data), .burst_done(burst_done), .be_rd(be_rd),
      .be_addr(be_addr), .be_win(be_win), .be_valid(be_valid),
      .be_data(be_data), .fill(fill));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // fetch monitor: R2, R3, R10
  always @(negedge clk) begin
    if (rst_n) begin
      if (be_rd) begin
        check(int'(be_addr) == exp_fetch, "R2 fetch address", int'(be_addr), exp_fetch);
        check(int'(fill) < DEPTH, "R3 strobe while full", int'(fill), DEPTH - 1);
        exp_fetch = (exp_fetch + 4) % (1 << AW);
        fetched++;
      end
      if (int'(fill) > DEPTH)
        check(1'b0, "R3 fill limit", int'(fill), DEPTH);
      if (burst_stop && be_rd)
        check(1'b0, "R10 strobe in stop cycle", 1, 0);
    end
  end

  task automatic burst(input int w, input int addr, input int len, input int gap);
    int m, wait_n;
    bit res;
    m = (w == 0 || w == 2) ? 2 : w;
    res = (tag == w) && (m == 2);
    @(negedge clk);
    burst_start = 1'b1;
    burst_win = WW'(w);
    burst_addr = AW'(addr);
    if (!res) begin
      exp_fetch = addr;
      exp_idx = addr >> 2;
      fetched = 0;
      delivered = 0;
    end
    tag = -1;
    @(negedge clk);
    burst_start = 1'b0;
    wait_n = 0;
    while (delivered < len) begin
      if (bus_valid && (wait_n % (gap + 1) == 0)) begin
        check(bus_data == word_of(w, exp_idx << 2),
              res ? "R5,R4,R8 replay order" : "R4,R7,R8 word order",
              int'(bus_data), int'(word_of(w, exp_idx << 2)));
        exp_idx++;
        delivered++;
        bus_take = 1'b1;
      end else begin
        bus_take = 1'b0;
      end
      wait_n++;
      @(negedge clk);
    end
    bus_take = 1'b0;
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check(burst_done == 1'b1, "R9 done pulse", int'(burst_done), 1);
    check(bus_valid == 1'b0, "R10 idle no valid", int'(bus_valid), 0);
    if (m == 2) begin
      check(int'(fill) == fetched - delivered, "R5 held count",
            int'(fill), fetched - delivered);
      tag = w;
    end else begin
      check(fill == '0, "R6 discard on stop", int'(fill), 0);
    end
    @(negedge clk);
    check(burst_done == 1'b0, "R9 single pulse", int'(burst_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fill == '0 && !bus_valid && !be_rd && !burst_done, "R1 reset state",
          {int'(fill), int'(bus_valid), int'(be_rd), int'(burst_done)}, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      rd_sync = 1'(s);
      tag = -1;
      burst(1, 'h300, 1, 0);
      burst(0, 'h100, 4, 0);
      burst(0, 'h000, 4, 1);
      burst(0, 'h000, 1, 0);
      for (int len = 1; len <= 6; len++)
        burst(0, 'h000, len, len % 3);
      burst(2, 'h200, 3, 2);
      burst(0, 'h140, 2, 0);
      burst(1, 'h300, 5, 0);
      burst(1, 'h380, 2, 1);
      burst(3, 'h040, 3, 0);
      burst(3, 'h080, 4, 2);
      burst(2, 'h600, 6, 0);
      burst(2, 'h000, 3, 1);
    end
    finish_run();
  end
endmodule